// File: doc/BRIEF.md
# Garbled AND Gate Generator

This block produces the garbled table for a single two-input AND gate of a garbled circuit. It is given the zero-labels of both input wires, the global free-XOR offset and a 32-bit gate number. It returns the zero-label of the gate's output wire and three 80-bit ciphertext rows. The label for logic one on any wire is its zero-label XOR the offset. The least significant bit of a label is its point-and-permute bit. Because of garbled row reduction, the row at permuted index 0 is never stored. Its hash is used directly as an output label.

Four identical SHA-1 engines run side by side, one for each combination of input values. A combinational selection network follows them. It picks the engine that lands on permuted row 0, folds that engine's hash into the other three, and puts the three stored rows in permuted order. The first stage of this network derives the output zero-label; the second stage orders the rows. Each engine runs one round per clock. One start pulse therefore yields a one-cycle done pulse a fixed 82 cycles later. A start that arrives while a gate is in flight is dropped.

Top module: `gand_gen`

## Requirements
- R1: After a synchronous reset, `done` is low and `outKey0`, `ct1`, `ct2` and `ct3` are all zero. A reset during a gate abandons that gate, and no `done` follows it.
- R2: If `start` is high in cycle n while the block is idle, `done` is high for exactly cycle n+82 and low in every other cycle.
- R3: Each row hash is SHA-1 over one 512-bit block. The block holds, from the most significant bit down: the A label (80 bits), the B label (80 bits), `gateId` (32 bits), a single 1 bit, 255 zero bits, and a 64-bit length field of 192. The hash used is the upper 80 bits of the 160-bit digest.
- R4: The one-label of a wire is its zero-label XOR `offsetR`. The permuted row index of an input pair is {lsb of A label, lsb of B label}, with A as the upper bit. The row for a given value pair therefore depends on the lsbs of `keyA0` and `keyB0`.
- R5: Let H0 be the hash of permuted row 0. `outKey0` equals H0 when the AND value of row 0 is 0, and H0 XOR `offsetR` when it is 1.
- R6: `ct1`, `ct2` and `ct3` hold permuted rows 1, 2 and 3 in that order. Each equals its row hash XOR the output label of that row's AND value, where the one-label is `outKey0` XOR `offsetR`.
- R7: A `start` that arrives while a gate is in flight (in any of the 81 cycles after the accepted start) is ignored. It neither moves nor adds a `done`, and it does not change the results.
- R8: All inputs are captured in the start cycle. Changes to them afterwards do not affect the results. The four result outputs change only in the cycle in which `done` is high.
- R9: A `start` in the same cycle as `done` is accepted, so gates can be issued back to back every 82 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin garbling one gate with the current inputs |
| keyA0 | input | 80 | Zero-label of input wire A |
| keyB0 | input | 80 | Zero-label of input wire B |
| offsetR | input | 80 | Global free-XOR offset |
| gateId | input | 32 | Gate number mixed into every row hash |
| done | output | 1 | One-cycle pulse: results are valid |
| outKey0 | output | 80 | Zero-label of the output wire |
| ct1 | output | 80 | Stored ciphertext for permuted row 1 |
| ct2 | output | 80 | Stored ciphertext for permuted row 2 |
| ct3 | output | 80 | Stored ciphertext for permuted row 3 |

## Verification
The hardest cases to reach from the ports are the selection corners. In each of these, permuted row 0 corresponds to a different value pair. When both zero-labels have their lsb set, row 0 carries AND value 1 and the output label picks up the offset. The stimulus forces every one of the four lsb combinations of `keyA0` and `keyB0` and compares all four outputs against an independent behavioural SHA-1 and garbling model. The stimulus also issues a start in the exact cycle `done` is high, keeps toggling `start` and all data inputs while a gate is in flight, and resets in the middle of a gate.

// File: rtl/gand_pkg.sv
package gand_pkg;

  localparam int ShaRounds  = 80;
  localparam int ShaBlockW  = 512;
  localparam int ShaLenW    = 64;
  localparam int ShaDigestW = 160;
  localparam int ShaWordW   = 32;
  localparam int RoundIdxW  = 7;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic                 load;    // capture inputs, seed the engines
    logic                 step;    // run one compression round
    logic                 finish;  // fold digests and register results
    logic [RoundIdxW-1:0] round;   // current round number
  } ctlStrobes_t;

  localparam logic [ShaDigestW-1:0] ShaIv = {
    32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0
  };

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] roundConst(input logic [RoundIdxW-1:0] t);
    if (t < RoundIdxW'(20)) return 32'h5A827999;
    if (t < RoundIdxW'(40)) return 32'h6ED9EBA1;
    if (t < RoundIdxW'(60)) return 32'h8F1BBCDC;
    return 32'hCA62C1D6;
  endfunction

  function automatic logic [31:0] roundMix(input logic [RoundIdxW-1:0] t,
                                           input logic [31:0] b,
                                           input logic [31:0] c,
                                           input logic [31:0] d);
    if (t < RoundIdxW'(20)) return (b & c) | (~b & d);
    if (t < RoundIdxW'(40)) return b ^ c ^ d;
    if (t < RoundIdxW'(60)) return (b & c) | (b & d) | (c & d);
    return b ^ c ^ d;
  endfunction

endpackage

// File: rtl/gand_sha1_core.sv
// Iterative single-block SHA-1: one load cycle, one round per clock.
// The truncated digest is valid from the cycle after the last round
// until the next load.
module gand_sha1_core import gand_pkg::*; #(
  parameter int OUT_W = 80
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 step,
  input  logic [RoundIdxW-1:0] round,
  input  logic [ShaBlockW-1:0] block,
  output logic [OUT_W-1:0]     hashTop
);

  localparam int WinDepth = ShaBlockW / ShaWordW;

  logic [ShaWordW-1:0] wA, wB, wC, wD, wE;
  logic [ShaWordW-1:0] win [WinDepth];
  logic [ShaWordW-1:0] nextWord;
  logic [ShaWordW-1:0] roundSum;

  // The window holds message words t .. t+15 during round t.
  assign nextWord = rotl(win[13] ^ win[8] ^ win[2] ^ win[0], 1);
  assign roundSum = rotl(wA, 5) + roundMix(round, wB, wC, wD) + wE
                  + roundConst(round) + win[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wA <= '0; wB <= '0; wC <= '0; wD <= '0; wE <= '0;
      for (int i = 0; i < WinDepth; i++) win[i] <= '0;
    end else if (load) begin
      {wA, wB, wC, wD, wE} <= ShaIv;
      for (int i = 0; i < WinDepth; i++)
        win[i] <= block[ShaBlockW-1-ShaWordW*i -: ShaWordW];
    end else if (step) begin
      wA <= roundSum;
      wB <= wA;
      wC <= rotl(wB, 30);
      wD <= wC;
      wE <= wD;
      for (int i = 0; i < WinDepth - 1; i++) win[i] <= win[i+1];
      win[WinDepth-1] <= nextWord;
    end
  end

  // The chaining add is folded into the output path. Only the upper
  // OUT_W bits are kept.
  assign hashTop = OUT_W'({wA + ShaIv[159:128], wB + ShaIv[127:96],
                           wC + ShaIv[95:64],   wD + ShaIv[63:32],
                           wE + ShaIv[31:0]} >> (ShaDigestW - OUT_W));

endmodule

// File: rtl/gand_ctrl.sv
// Sequencer: idle -> load -> ShaRounds rounds -> finish -> idle.
module gand_ctrl import gand_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output ctlStrobes_t ctl
);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  localparam logic [RoundIdxW-1:0] FinishCount = RoundIdxW'(ShaRounds);

  state_t               state;
  logic [RoundIdxW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      count <= '0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state <= ST_RUN;
        count <= '0;
      end
    end else begin
      if (count == FinishCount) state <= ST_IDLE;
      else                      count <= count + 1'b1;
    end
  end

  always_comb begin
    ctl.load   = (state == ST_IDLE) && start;
    ctl.step   = (state == ST_RUN) && (count < FinishCount);
    ctl.finish = (state == ST_RUN) && (count == FinishCount);
    ctl.round  = count;
  end

endmodule

// File: rtl/gand_datapath.sv
// Four hash engines, one per input value pair, followed by the
// row-reduction selection network and the result registers.
module gand_datapath import gand_pkg::*; #(
  parameter int KEY_W = 80,
  parameter int ID_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       ctl,
  input  logic [KEY_W-1:0]  keyA0,
  input  logic [KEY_W-1:0]  keyB0,
  input  logic [KEY_W-1:0]  offR,
  input  logic [ID_W-1:0]   gateId,
  output logic              done,
  output logic [KEY_W-1:0]  outKey0,
  output logic [KEY_W-1:0]  ct1,
  output logic [KEY_W-1:0]  ct2,
  output logic [KEY_W-1:0]  ct3
);

  localparam int Rows     = 4;
  localparam int MsgW     = 2 * KEY_W + ID_W;
  localparam int PadZeroW = ShaBlockW - ShaLenW - 1 - MsgW;
  localparam int Stored   = Rows - 1;

  logic [KEY_W-1:0] hashTop [Rows];
  logic [KEY_W-1:0] offHeld;
  logic [1:0]       permHeld;

  // Engine e hashes the value pair (e>>1, e&1). The labels are built
  // from the ports in the load cycle only.
  for (genvar e = 0; e < Rows; e++) begin : g_eng
    localparam bit ValA = ((e >> 1) & 1) == 1;
    localparam bit ValB = (e & 1) == 1;
    logic [KEY_W-1:0]     keyA, keyB;
    logic [ShaBlockW-1:0] blk;

    assign keyA = ValA ? (keyA0 ^ offR) : keyA0;
    assign keyB = ValB ? (keyB0 ^ offR) : keyB0;
    assign blk  = {keyA, keyB, gateId, 1'b1, {PadZeroW{1'b0}},
                   ShaLenW'(MsgW)};

    gand_sha1_core #(.OUT_W(KEY_W)) u_core (
      .clk     (clk),
      .rst     (rst),
      .load    (ctl.load),
      .step    (ctl.step),
      .round   (ctl.round),
      .block   (blk),
      .hashTop (hashTop[e])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offHeld  <= '0;
      permHeld <= '0;
    end else if (ctl.load) begin
      offHeld  <= offR;
      permHeld <= {keyA0[0], keyB0[0]};
    end
  end

  // Stage 1: the engine whose value pair lands on permuted row 0 is
  // the one matching the zero-label permute bits. Its hash becomes an
  // output label and is folded into all other rows.
  // Stage 2: permuted row r is served by engine r ^ permHeld.
  logic [KEY_W-1:0] zeroHash, zeroKey;
  logic             zeroAnd;
  logic [KEY_W-1:0] mixed   [Rows];
  logic [KEY_W-1:0] ordered [Stored];

  always_comb begin
    zeroHash = hashTop[permHeld];
    zeroAnd  = &permHeld;
    zeroKey  = zeroAnd ? (zeroHash ^ offHeld) : zeroHash;
    for (int e = 0; e < Rows; e++) begin
      mixed[e] = hashTop[e] ^ zeroHash;
      if ((e == Rows - 1) != zeroAnd) mixed[e] = mixed[e] ^ offHeld;
    end
    for (int r = 1; r < Rows; r++)
      ordered[r-1] = mixed[2'(r) ^ permHeld];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      outKey0 <= '0;
      ct1     <= '0;
      ct2     <= '0;
      ct3     <= '0;
    end else begin
      done <= ctl.finish;
      if (ctl.finish) begin
        outKey0 <= zeroKey;
        ct1     <= ordered[0];
        ct2     <= ordered[1];
        ct3     <= ordered[2];
      end
    end
  end

endmodule

// File: rtl/gand_gen.sv
// Garbled AND gate generator top: sequencer plus datapath.
module gand_gen import gand_pkg::*; #(
  parameter int KEY_W = 80,
  parameter int ID_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [KEY_W-1:0] keyA0,
  input  logic [KEY_W-1:0] keyB0,
  input  logic [KEY_W-1:0] offsetR,
  input  logic [ID_W-1:0]  gateId,
  output logic             done,
  output logic [KEY_W-1:0] outKey0,
  output logic [KEY_W-1:0] ct1,
  output logic [KEY_W-1:0] ct2,
  output logic [KEY_W-1:0] ct3
);

  ctlStrobes_t ctl;

  gand_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ctl   (ctl)
  );

  gand_datapath #(.KEY_W(KEY_W), .ID_W(ID_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .keyA0   (keyA0),
    .keyB0   (keyB0),
    .offR    (offsetR),
    .gateId  (gateId),
    .done    (done),
    .outKey0 (outKey0),
    .ct1     (ct1),
    .ct2     (ct2),
    .ct3     (ct3)
  );

endmodule

// File: rtl/gand_gen_chk.sv
// Protocol checker for gand_gen, attached through bind.
module gand_gen_chk import gand_pkg::*; #(
  parameter int KEY_W = 80
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic [KEY_W-1:0] outKey0,
  input logic [KEY_W-1:0] ct1,
  input logic [KEY_W-1:0] ct2,
  input logic [KEY_W-1:0] ct3
);

  logic chkBusy;
  logic expDone;
  int   chkCnt;

  // Independent occupancy counter: accept only when idle, then count
  // out the rounds. The pulse is due one edge after the count ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      chkBusy <= 1'b0;
      expDone <= 1'b0;
      chkCnt  <= 0;
    end else begin
      expDone <= 1'b0;
      if (chkBusy) begin
        if (chkCnt == ShaRounds) begin
          chkBusy <= 1'b0;
          expDone <= 1'b1;
        end else begin
          chkCnt <= chkCnt + 1;
        end
      end else if (start) begin
        chkBusy <= 1'b1;
        chkCnt  <= 0;
      end
    end
  end

  // R2 R7 R9
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    done == expDone);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> ($stable(outKey0) && $stable(ct1) &&
                                $stable(ct2) && $stable(ct3)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!done && outKey0 == '0 && ct1 == '0 && ct2 == '0 && ct3 == '0));

endmodule

bind gand_gen gand_gen_chk #(.KEY_W(KEY_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .done    (done),
  .outKey0 (outKey0),
  .ct1     (ct1),
  .ct2     (ct2),
  .ct3     (ct3)
);

// File: tb/sim_gand_gen.sv
module sim_gand_gen;

  localparam int KEY_W = 80;
  localparam int ID_W  = 32;
  localparam int MSG_W = 2 * KEY_W + ID_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [KEY_W-1:0] keyA0 = '0, keyB0 = '0, offsetR = '0;
  logic [ID_W-1:0]  gateId = '0;
  logic             done;
  logic [KEY_W-1:0] outKey0, ct1, ct2, ct3;

  always #2 clk = ~clk;  // 250 MHz

  gand_gen #(.KEY_W(KEY_W), .ID_W(ID_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .keyA0(keyA0), .keyB0(keyB0),
    .offsetR(offsetR), .gateId(gateId), .done(done), .outKey0(outKey0),
    .ct1(ct1), .ct2(ct2), .ct3(ct3)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";
  bit    finished = 1'b0;
  int    cyc = 0;

  typedef struct packed {
    logic [KEY_W-1:0] k0;
    logic [KEY_W-1:0] c1;
    logic [KEY_W-1:0] c2;
    logic [KEY_W-1:0] c3;
  } res_t;

  // ---------------- behavioural reference ----------------
  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] refSha1(input logic [511:0] blk);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, tmp;
    for (int t = 0; t < 16; t++) w[t] = blk[511 - 32*t -: 32];
    for (int t = 16; t < 80; t++) w[t] = rl(w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16], 1);
    a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE;
    d = 32'h10325476; e = 32'hC3D2E1F0;
    for (int t = 0; t < 80; t++) begin
      if (t < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (t < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (t < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      tmp = rl(a, 5) + f + e + k + w[t];
      e = d; d = c; c = rl(b, 30); b = a; a = tmp;
    end
    return {a + 32'h67452301, b + 32'hEFCDAB89, c + 32'h98BADCFE,
            d + 32'h10325476, e + 32'hC3D2E1F0};
  endfunction

  function automatic res_t refGarble(input logic [KEY_W-1:0] a0,
                                     input logic [KEY_W-1:0] b0,
                                     input logic [KEY_W-1:0] r,
                                     input logic [ID_W-1:0]  id);
    logic [KEY_W-1:0] h [4];
    logic             v [4];
    logic [KEY_W-1:0] lab [4];
    res_t             res;
    for (int row = 0; row < 4; row++) begin
      logic             va, vb;
      logic [KEY_W-1:0] ka, kb;
      logic [159:0]     dg;
      va = (((row >> 1) & 1) == 1) ^ a0[0];
      vb = ((row & 1) == 1) ^ b0[0];
      ka = va ? a0 ^ r : a0;
      kb = vb ? b0 ^ r : b0;
      dg = refSha1({ka, kb, id, 1'b1, {(512 - 65 - MSG_W){1'b0}}, 64'(MSG_W)});
      h[row] = dg[159 -: KEY_W];
      v[row] = va & vb;
    end
    res.k0 = v[0] ? h[0] ^ r : h[0];
    for (int row = 1; row < 4; row++) lab[row] = v[row] ? res.k0 ^ r : res.k0;
    lab[0] = '0;
    res.c1 = h[1] ^ lab[1];
    res.c2 = h[2] ^ lab[2];
    res.c3 = h[3] ^ lab[3];
    return res;
  endfunction

  // ---------------- cycle model ----------------
  logic mBusy = 1'b0;
  int   mCnt = 0;
  logic mExpDone = 1'b0;
  res_t mOut = '0;
  res_t mPend = '0;

  always @(posedge clk) begin
    if (rst) begin
      mBusy <= 1'b0; mCnt <= 0; mExpDone <= 1'b0; mOut <= '0;
    end else begin
      mExpDone <= 1'b0;
      if (mBusy) begin
        if (mCnt == 1) begin
          mBusy <= 1'b0; mExpDone <= 1'b1; mOut <= mPend;
        end
        mCnt <= mCnt - 1;
      end else if (start) begin
        mBusy <= 1'b1;
        mCnt  <= 81;
        mPend <= refGarble(keyA0, keyB0, offsetR, gateId);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [KEY_W-1:0] got, input logic [KEY_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (phase %s) %s got %h exp %h", tag, phase, what, got, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      chk(done === mExpDone, "R2", "done", KEY_W'(done), KEY_W'(mExpDone));
      if (mExpDone) begin
        chk(outKey0 === mOut.k0, "R5", "outKey0", outKey0, mOut.k0);
        chk(ct1 === mOut.c1, "R6", "ct1", ct1, mOut.c1);
        chk(ct2 === mOut.c2, "R6", "ct2", ct2, mOut.c2);
        chk(ct3 === mOut.c3, "R6", "ct3", ct3, mOut.c3);
      end else begin
        chk(outKey0 === mOut.k0, "R8", "held outKey0", outKey0, mOut.k0);
        chk({ct1, ct2, ct3} === {mOut.c1, mOut.c2, mOut.c3}, "R8", "held ct1",
            ct1, mOut.c1);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [KEY_W-1:0] rnd();
    return KEY_W'({$urandom, $urandom, $urandom});
  endfunction

  // Start one gate at the current negedge. Returns at the negedge of the
  // done cycle, so a following call starts back to back.
  task automatic runGate(input logic [KEY_W-1:0] a, input logic [KEY_W-1:0] b,
                         input logic [KEY_W-1:0] r, input logic [ID_W-1:0] id,
                         input bit noisy);
    keyA0 = a; keyB0 = b; offsetR = r; gateId = id; start = 1'b1;
    for (int i = 0; i < 81; i++) begin
      @(negedge clk);
      start   = noisy ? 1'($urandom % 2) : 1'b0;
      keyA0   = rnd(); keyB0 = rnd(); offsetR = rnd(); gateId = $urandom;  // R8
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic checkCleared();
    chk(done === 1'b0, "R1", "done after reset", KEY_W'(done), '0);
    chk(outKey0 === '0, "R1", "outKey0 after reset", outKey0, '0);
    chk((ct1 | ct2 | ct3) === '0, "R1", "rows after reset", ct1 | ct2 | ct3, '0);
  endtask

  initial begin
    logic [159:0] dg;
    // Bench reference self-test on a known digest (R3).
    dg = refSha1({24'h616263, 1'b1, 423'b0, 64'd24});
    chk(dg[159:80] === 80'ha9993e364706816aba3e, "R3", "reference hash",
        dg[159:80], 80'ha9993e364706816aba3e);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R1";
    checkCleared();
    @(negedge clk);

    // R3: plain gates
    phase = "R3";
    for (int g = 0; g < 3; g++) begin
      runGate(rnd(), rnd(), rnd() | 80'd1, $urandom, 1'b0);
      repeat (3) @(negedge clk);
    end

    // R4 / R5: every permute-bit combination of the zero-labels
    phase = "R4";
    for (int p = 0; p < 4; p++) begin
      logic [KEY_W-1:0] a, b;
      a = rnd(); b = rnd();
      a[0] = ((p >> 1) & 1) == 1;
      b[0] = (p & 1) == 1;
      runGate(a, b, rnd() | 80'd1, 32'(p) + 32'h100, 1'b0);
      repeat (2) @(negedge clk);
    end
    phase = "R5";
    runGate(rnd() | 80'd1, rnd() | 80'd1, rnd() | 80'd1, 32'hFFFF_FFFF, 1'b0);
    repeat (2) @(negedge clk);
    runGate('0, '0, 80'd1, 32'd0, 1'b0);
    repeat (2) @(negedge clk);

    // R7: start toggled throughout the busy window
    phase = "R7";
    for (int g = 0; g < 3; g++) begin
      runGate(rnd(), rnd(), rnd() | 80'd1, $urandom, 1'b1);
      repeat (3) @(negedge clk);
    end

    // R9: back-to-back issue in the done cycle
    phase = "R9";
    for (int g = 0; g < 4; g++) runGate(rnd(), rnd(), rnd() | 80'd1, $urandom, 1'b0);
    repeat (3) @(negedge clk);

    // R1: reset in the middle of a gate
    phase = "R1";
    keyA0 = rnd(); keyB0 = rnd(); offsetR = rnd() | 80'd1; gateId = $urandom;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    checkCleared();
    repeat (90) @(negedge clk);
    checkCleared();
    runGate(rnd(), rnd(), rnd() | 80'd1, $urandom, 1'b0);
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule